// File: doc/BRIEF.md
# PLL clock mode controller

This block decides which clock a small microcontroller core and its audio processor run from. Software writes two byte-wide control registers over a simple single-cycle register bus. From the register fields the block drives the PLL enable, the PLL frequency code, the divide ratio for the core clock, the divide ratio for the audio clock, and the select between the 32.768 kHz low-speed domain and the PLL domain.

A lock timer advances on a one-cycle tick marking each 32.768 kHz reference period. It keeps the PLL from becoming the clock source until 328 reference periods (about 10 ms) have passed since the PLL was switched on or retuned. Until then the block stays on the low-speed clock and flags the fallback. The block also raises an idle request while a halt is executing with the crystal oscillator enabled, and it reports the resulting core and audio frequencies as numbers in units of 1.024 kHz.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After reset, register A (bus_addr 0) reads 0x26 and register B (bus_addr 1) reads 0x01. The PLL is off, pll_ready is 0, clk_sel_pll is 0, and both frequency outputs read 32.
- R2: Register A bits 7:6 hold the PLL frequency code. Codes 00, 01, 10 and 11 give 8000, 10000, 12000 and 16000 units of 1.024 kHz. Bit 3 enables the PLL.
- R3: Register A bits 2:1 set the core divide ratio. Code 01 divides by 1, code 10 by 2, and codes 11 and 00 by 4. While the PLL is the source, mcu_freq equals the PLL frequency divided by that ratio.
- R4: Register A bit 5 sets the audio ratio (0 divides by 1, 1 divides by 2) and bit 4 turns the audio processor on. While the PLL is the source, aud_freq equals the PLL frequency divided by that ratio.
- R5: While the PLL enable bit is 0, pll_ready stays 0 whatever ticks arrive, and both frequency outputs read 32, regardless of the frequency and divider fields.
- R6: After a write sets the PLL enable, pll_ready is still 0 after 327 ref_tick pulses and becomes 1 on the 328th.
- R7: A write that changes the enable bit or the frequency code clears pll_ready in the next cycle and restarts the count.
- R8: clk_sel_pll is 1 only when register B bit 0 is 0, the PLL is enabled and pll_ready is 1. fallback is 1 when register B bit 0 is 0 and clk_sel_pll is 0. When clk_sel_pll is 0, both frequency outputs read 32.
- R9: While the audio processor is on and clk_sel_pll is 1, a write to register A leaves bits 2:1 unchanged and stores its other bits. In any other state the divider field is written normally.
- R10: idle_req is 1 exactly when halt is 1 and register A bit 0 (crystal enable) is 1.
- R11: Register B stores only bit 0. Its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 is A, 1 is B |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| halt | input | 1 | Core is executing a halt |
| pll_en | output | 1 | PLL enable |
| pll_freq_code | output | 2 | PLL frequency code |
| mcu_ratio | output | 3 | Core divide ratio: 1, 2 or 4 |
| aud_ratio | output | 2 | Audio divide ratio: 1 or 2 |
| audio_on | output | 1 | Audio processor enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| clk_sel_pll | output | 1 | 1 selects the PLL domain as clock source |
| fallback | output | 1 | PLL requested but not yet usable |
| pll_ready | output | 1 | Lock timer has completed |
| idle_req | output | 1 | Idle-mode request |
| mcu_freq | output | 14 | Core clock frequency in units of 1.024 kHz |
| aud_freq | output | 14 | Audio clock frequency in units of 1.024 kHz |

## Verification
The hardest state to reach from the ports is the one where the divider write is masked. It needs the PLL locked, the speed bit cleared and the audio processor switched on, all at once. The stimulus first holds ref_tick high for the full lock count. It then turns the audio processor on with a separate write, and only after that tries to change the divider, reading register A back to confirm the field did not move. The same read is repeated with the speed bit set to show that the mask lifts.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

    localparam int FREQ_W = 14;

    typedef struct packed {
        logic [1:0] freq;
        logic       aud_div;
        logic       aud_on;
        logic       pll_en;
        logic [1:0] mcu_div;
        logic       xtal_en;
    } ctrl_a_t;

    function automatic logic [FREQ_W-1:0] pll_units(input logic [1:0] code);
        logic [FREQ_W-1:0] u;
        case (code)
            2'b00:   u = FREQ_W'(8000);
            2'b01:   u = FREQ_W'(10000);
            2'b10:   u = FREQ_W'(12000);
            default: u = FREQ_W'(16000);
        endcase
        return u;
    endfunction

    function automatic logic [1:0] mcu_shift(input logic [1:0] div);
        logic [1:0] s;
        case (div)
            2'b01:   s = 2'd0;
            2'b10:   s = 2'd1;
            default: s = 2'd2;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pll_mode_regs.sv
module pll_mode_regs
    import pll_mode_pkg::*;
#(
    parameter logic [7:0] RST_A = 8'h26,
    parameter logic       RST_SPEED_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pll_active,
    output ctrl_a_t    ctrl_a,
    output logic       speed_low,
    output logic       restart
);

    typedef struct packed {
        ctrl_a_t a;
        logic    speed_low;
    } reg_state_t;

    reg_state_t st_d, st_q;
    ctrl_a_t    nxt_a;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        nxt_a   = ctrl_a_t'(bus_wdata);
        if (pll_active && st_q.a.aud_on) begin
            nxt_a.mcu_div = st_q.a.mcu_div;
        end
        if (bus_wr) begin
            if (!bus_addr) begin
                st_d.a  = nxt_a;
                restart = (nxt_a.freq != st_q.a.freq) || (nxt_a.pll_en != st_q.a.pll_en);
            end else begin
                st_d.speed_low = bus_wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.a         <= ctrl_a_t'(RST_A);
            st_q.speed_low <= RST_SPEED_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_a    = st_q.a;
    assign speed_low = st_q.speed_low;
    assign bus_rdata = bus_addr ? {7'b0, st_q.speed_low} : 8'(st_q.a);

endmodule

// File: rtl/pll_mode_lock.sv
module pll_mode_lock #(
    parameter int LOCK_TICKS = 328,
    localparam int CNT_W = $clog2(LOCK_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic pll_en,
    input  logic restart,
    output logic ready
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart || !pll_en) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else if (ref_tick && !st_q.ready) begin
            if (st_q.cnt == CNT_W'(LOCK_TICKS - 1)) begin
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;

endmodule

// File: rtl/pll_mode_freq.sv
module pll_mode_freq
    import pll_mode_pkg::*;
#(
    parameter int LOW_UNITS = 32
) (
    input  logic [1:0]        freq_code,
    input  logic [1:0]        mcu_div,
    input  logic              aud_div,
    input  logic              sel_pll,
    output logic [2:0]        mcu_ratio,
    output logic [1:0]        aud_ratio,
    output logic [FREQ_W-1:0] mcu_freq,
    output logic [FREQ_W-1:0] aud_freq
);

    logic [FREQ_W-1:0] base;
    logic [1:0]        msh;

    always_comb begin
        base      = pll_units(freq_code);
        msh       = mcu_shift(mcu_div);
        mcu_ratio = 3'(1 << msh);
        aud_ratio = aud_div ? 2'd2 : 2'd1;
        if (sel_pll) begin
            mcu_freq = base >> msh;
            aud_freq = base >> aud_div;
        end else begin
            mcu_freq = FREQ_W'(LOW_UNITS);
            aud_freq = FREQ_W'(LOW_UNITS);
        end
    end

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int LOCK_TICKS = 328,
    parameter int LOW_UNITS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              halt,
    output logic              pll_en,
    output logic [1:0]        pll_freq_code,
    output logic [2:0]        mcu_ratio,
    output logic [1:0]        aud_ratio,
    output logic              audio_on,
    output logic              xtal_en,
    output logic              clk_sel_pll,
    output logic              fallback,
    output logic              pll_ready,
    output logic              idle_req,
    output logic [FREQ_W-1:0] mcu_freq,
    output logic [FREQ_W-1:0] aud_freq
);

    ctrl_a_t ctrl_a;
    logic    speed_low;
    logic    restart;
    logic    ready;

    pll_mode_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pll_active (clk_sel_pll),
        .ctrl_a     (ctrl_a),
        .speed_low  (speed_low),
        .restart    (restart)
    );

    pll_mode_lock #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .pll_en   (ctrl_a.pll_en),
        .restart  (restart),
        .ready    (ready)
    );

    pll_mode_freq #(.LOW_UNITS(LOW_UNITS)) u_freq (
        .freq_code (ctrl_a.freq),
        .mcu_div   (ctrl_a.mcu_div),
        .aud_div   (ctrl_a.aud_div),
        .sel_pll   (clk_sel_pll),
        .mcu_ratio (mcu_ratio),
        .aud_ratio (aud_ratio),
        .mcu_freq  (mcu_freq),
        .aud_freq  (aud_freq)
    );

    assign clk_sel_pll   = !speed_low && ctrl_a.pll_en && ready;
    assign fallback      = !speed_low && !clk_sel_pll;
    assign pll_ready     = ready;
    assign pll_en        = ctrl_a.pll_en;
    assign pll_freq_code = ctrl_a.freq;
    assign audio_on      = ctrl_a.aud_on;
    assign xtal_en       = ctrl_a.xtal_en;
    assign idle_req      = halt && ctrl_a.xtal_en;

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk #(
    parameter int FW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          halt,
    input logic          pll_en,
    input logic [2:0]    mcu_ratio,
    input logic          audio_on,
    input logic          xtal_en,
    input logic          clk_sel_pll,
    input logic          pll_ready,
    input logic          idle_req,
    input logic [FW-1:0] mcu_freq,
    input logic [FW-1:0] aud_freq
);

    // R5
    ready_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> !pll_ready);

    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_ready) |-> (pll_en && $past(pll_en)));

    // R7
    enable_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[3] && !pll_en) |=> !pll_ready);

    // R8
    low_speed_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_sel_pll |-> (mcu_freq == FW'(32) && aud_freq == FW'(32)));

    // R9
    div_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_pll && audio_on) |=> $stable(mcu_ratio));

    // R10
    idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> (halt && xtal_en));

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk #(.FW(14)) u_chk (.*);

// File: tb/sim_pll_mode_ctrl.sv
module sim_pll_mode_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        halt = 1'b0;
    logic        pll_en;
    logic [1:0]  pll_freq_code;
    logic [2:0]  mcu_ratio;
    logic [1:0]  aud_ratio;
    logic        audio_on;
    logic        xtal_en;
    logic        clk_sel_pll;
    logic        fallback;
    logic        pll_ready;
    logic        idle_req;
    logic [13:0] mcu_freq;
    logic [13:0] aud_freq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_mode_ctrl u0 (.*);

    // frequency code, core divider code, audio ratio bit, expected core, expected audio
    typedef struct packed {
        logic [1:0]  f;
        logic [1:0]  d;
        logic        a;
        logic [13:0] em;
        logic [13:0] ea;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{2'b00, 2'b01, 1'b0, 14'd8000,  14'd8000},
        '{2'b00, 2'b10, 1'b1, 14'd4000,  14'd4000},
        '{2'b00, 2'b11, 1'b0, 14'd2000,  14'd8000},
        '{2'b00, 2'b00, 1'b1, 14'd2000,  14'd4000},
        '{2'b01, 2'b01, 1'b0, 14'd10000, 14'd10000},
        '{2'b01, 2'b10, 1'b1, 14'd5000,  14'd5000},
        '{2'b01, 2'b11, 1'b0, 14'd2500,  14'd10000},
        '{2'b01, 2'b00, 1'b1, 14'd2500,  14'd5000},
        '{2'b10, 2'b01, 1'b0, 14'd12000, 14'd12000},
        '{2'b10, 2'b10, 1'b1, 14'd6000,  14'd6000},
        '{2'b10, 2'b11, 1'b0, 14'd3000,  14'd12000},
        '{2'b10, 2'b00, 1'b1, 14'd3000,  14'd6000},
        '{2'b11, 2'b01, 1'b0, 14'd16000, 14'd16000},
        '{2'b11, 2'b10, 1'b1, 14'd8000,  14'd8000},
        '{2'b11, 2'b11, 1'b0, 14'd4000,  14'd16000},
        '{2'b11, 2'b00, 1'b1, 14'd4000,  14'd8000}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, r); check("R1 regA", r, 8'h26);
        rd(1'b1, r); check("R1 regB", r, 8'h01);
        check("R1 pll_en", pll_en, 0);
        check("R1 pll_ready", pll_ready, 0);
        check("R1 clk_sel", clk_sel_pll, 0);
        check("R1 mcu_freq", mcu_freq, 32);
        check("R1 aud_freq", aud_freq, 32);

        // R11 only bit 0 of register B is kept
        wr(1'b1, 8'hFE);
        rd(1'b1, r); check("R11 regB", r, 8'h00);

        // R5 PLL off: low-speed frequencies, no lock
        wr(1'b0, 8'hC2);
        check("R5 mcu_freq", mcu_freq, 32);
        check("R5 aud_freq", aud_freq, 32);
        check("R8 fallback", fallback, 1);
        ticks(400);
        check("R5 ready off", pll_ready, 0);

        // R6 lock timing after enable
        wr(1'b0, 8'h0A);
        check("R7 ready after enable", pll_ready, 0);
        ticks(327);
        check("R6 ready at 327", pll_ready, 0);
        check("R8 no pll before lock", clk_sel_pll, 0);
        ticks(1);
        check("R6 ready at 328", pll_ready, 1);
        check("R8 pll selected", clk_sel_pll, 1);
        check("R8 fallback cleared", fallback, 0);

        // R2 R3 R4 table walk
        for (int i = 0; i < 16; i++) begin
            wr(1'b0, {VECS[i].f, VECS[i].a, 1'b0, 1'b1, VECS[i].d, 1'b0});
            if (i % 4 == 0) ticks(330);
            check("R2 freq code", pll_freq_code, VECS[i].f);
            check("R3 mcu_freq", mcu_freq, VECS[i].em);
            check("R4 aud_freq", aud_freq, VECS[i].ea);
            check("R4 aud_ratio", aud_ratio, VECS[i].a ? 2 : 1);
        end

        // R7 retune restarts the lock
        wr(1'b0, 8'h8A);
        check("R7 ready cleared", pll_ready, 0);
        check("R7 fallback", fallback, 1);
        check("R7 mcu_freq", mcu_freq, 32);
        ticks(327);
        check("R7 relock 327", pll_ready, 0);
        ticks(1);
        check("R7 relock 328", pll_ready, 1);
        check("R3 mcu_freq 12000", mcu_freq, 12000);

        // R8 speed bit forces the low-speed clock
        wr(1'b1, 8'h01);
        check("R8 sel low", clk_sel_pll, 0);
        check("R8 no fallback", fallback, 0);
        check("R8 mcu low", mcu_freq, 32);
        check("R8 ready kept", pll_ready, 1);

        // R9 divider frozen with audio on and PLL active
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h9A);
        check("R9 active", clk_sel_pll, 1);
        wr(1'b0, 8'h9C);
        rd(1'b0, r); check("R9 div held", r, 8'h9A);
        check("R9 mcu_freq held", mcu_freq, 12000);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h9C);
        rd(1'b0, r); check("R9 div written", r, 8'h9C);

        // R10 idle request
        wr(1'b0, 8'h9D);
        @(negedge clk); halt = 1'b1;
        #1 check("R10 idle set", idle_req, 1);
        wr(1'b0, 8'h9C);
        check("R10 idle no xtal", idle_req, 0);
        halt = 1'b0;
        wr(1'b0, 8'h9D);
        check("R10 idle no halt", idle_req, 0);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule